// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit wide first-in first-out buffer. It has a write side and a read side, and each side has its own clock, reset and enable. The two clocks may be unrelated, or they may be one and the same net. Each side keeps a binary pointer and a Gray-coded copy of it. Each side sees the other side's pointer only after that pointer has passed through a two-flop synchroniser. The status flags therefore lag the true fill level by the synchroniser delay, and the lag always errs on the safe side: a late Full still prevents an overwrite, and a late Empty still prevents a read of unwritten data.

The write side also hosts two threshold registers, one for the near-empty flag and one for the near-full flag. Both reset to 7. While the load input is held high, each write-enabled cycle stores the low byte of the write data into the next of four byte fields, and no word enters the queue. The four fields are taken in this order: empty threshold low byte, empty threshold high byte, full threshold low byte, full threshold high byte. After the fourth field the sequence returns to the first. A half-full flag reports when more than half of the storage is in use. The depth is a parameter, with the supported values 256, 512, 1024, 2048 and 4096 words.

Top module: `pflag_fifo`

## Requirements
- R1: Words come out in the order they were written, with all 18 bits intact, whether the clocks are tied or unrelated. A write happens on a write-clock rising edge when `wr_en`=1, `load_en`=0 and `full`=0. A read happens on a read-clock rising edge when `rd_en`=1 and `empty`=0, and `rd_data` holds the word read from that edge onward.
- R2: While the resets are low and right after they are released, the outputs are as follows: `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, `half_full`=0 and `rd_data`=0.
- R3: A write attempted while `full`=1 is dropped and does not move the write pointer. No extra word is ever read out because of it.
- R4: A read attempted while `empty`=1 is dropped. The read pointer does not move and `rd_data` keeps its value.
- R5: `full`=1 exactly when the occupancy equals DEPTH. `empty`=1 exactly when the occupancy is 0. Both are judged once the synchroniser delay has passed.
- R6: `half_full`=1 exactly when the occupancy is greater than DEPTH/2.
- R7: `almost_empty`=1 when the occupancy is at or below the empty threshold. `almost_full`=1 when the free space is at or below the full threshold. Both thresholds are 7 after reset.
- R8: While `load_en`=1, each cycle with `wr_en`=1 writes `wr_data[7:0]` into one byte field. The fields are taken in the rotation empty-low, empty-high, full-low, full-high, and then the rotation wraps. Each threshold is {high byte, low byte} truncated to log2(DEPTH) bits. No word enters the queue during a load.
- R9: Any cycle with `load_en`=0 returns the rotation to the empty-low field.
- R10: Each Gray-coded pointer changes by at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side synchronous active-low reset |
| wr_en | input | 1 | Write enable (stores a threshold byte while `load_en` is high) |
| load_en | input | 1 | Selects threshold loading instead of a data write |
| wr_data | input | 18 | Word to store; bits 7:0 carry the threshold bytes |
| full | output | 1 | No free word |
| almost_full | output | 1 | Free space at or below the full threshold |
| half_full | output | 1 | Occupancy above DEPTH/2 |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side synchronous active-low reset |
| rd_en | input | 1 | Read enable |
| rd_data | output | 18 | Last word read |
| empty | output | 1 | No stored word |
| almost_empty | output | 1 | Occupancy at or below the empty threshold |

## Verification
A wrong pointer shows up on the ports at the next read that reaches the affected entry. The symptom is a word out of order, a repeated word, or a word that was never written. A scoreboard comparison catches it on the cycle after that read. A wrong synchronised pointer or a wrong threshold field shows up as a flag with the wrong value. The flags are compared against the known fill level a few cycles after each single write, once the two synchroniser stages have settled. A wrong load rotation is exposed because a threshold byte landing in the wrong field moves the edge of `almost_empty` or `almost_full` by a whole count.

// File: rtl/pflag_fifo_pkg.sv
// Shared types for the dual-clock FIFO with programmable threshold flags.
// Assumes nothing beyond the standard language.
package pflag_fifo_pkg;

    // Byte field written by the threshold loader; the order is the load rotation.
    typedef enum logic [1:0] {
        FLD_EMPTY_LO = 2'd0,
        FLD_EMPTY_HI = 2'd1,
        FLD_FULL_LO  = 2'd2,
        FLD_FULL_HI  = 2'd3
    } thr_field_e;

endpackage

// File: rtl/pflag_ptr.sv
// Binary pointer with a registered Gray-coded twin.
// Assumes inc is already qualified by the full or empty condition of the caller.
module pflag_ptr #(
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [PW-1:0] bin,
    output logic [PW-1:0] gray
);
    logic [PW-1:0] bin_nx;

    // Next binary value: advance by one on an accepted access.
    assign bin_nx = bin + PW'(inc);

    // Register the binary pointer and its Gray code together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
        end else begin
            bin  <= bin_nx;
            gray <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/pflag_sync2.sv
// Two-flop synchroniser for a Gray-coded bus.
// Assumes at most one bit of d changes between samples.
module pflag_sync2 #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two stages of resampling into the local clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pflag_ram.sv
// Storage array with one write port and one registered read port on separate clocks.
// Assumes the caller never writes and reads the same entry in the same instant.
module pflag_ram #(
    parameter int DW = 18,
    parameter int AW = 8
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    // Store an accepted write.
    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Capture the word addressed by an accepted read; hold otherwise.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n)  rdata <= '0;
        else if (re)    rdata <= mem[raddr];
    end
endmodule

// File: rtl/pflag_thr_load.sv
// Threshold register bank loaded one byte per write-enabled cycle in a fixed rotation.
// Assumes load_en and wr_en are synchronous to clk; AW is at most 16.
module pflag_thr_load #(
    parameter int AW          = 8,
    parameter int THR_DEFAULT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic          wr_en,
    input  logic [7:0]    din,
    output logic [AW-1:0] empty_thr,
    output logic [AW-1:0] full_thr
);
    import pflag_fifo_pkg::*;

    localparam logic [15:0] DEF16 = 16'(THR_DEFAULT);

    thr_field_e sel;
    logic [7:0] e_lo, e_hi, f_lo, f_hi;

    // Rotation state and byte fields; the rotation restarts whenever load is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel  <= FLD_EMPTY_LO;
            e_lo <= DEF16[7:0];
            e_hi <= DEF16[15:8];
            f_lo <= DEF16[7:0];
            f_hi <= DEF16[15:8];
        end else if (!load_en) begin
            sel <= FLD_EMPTY_LO;
        end else if (wr_en) begin
            case (sel)
                FLD_EMPTY_LO: e_lo <= din;
                FLD_EMPTY_HI: e_hi <= din;
                FLD_FULL_LO:  f_lo <= din;
                default:      f_hi <= din;
            endcase
            sel <= thr_field_e'(sel + 2'd1);
        end
    end

    // Assemble each threshold from its two bytes.
    assign empty_thr = AW'({e_hi, e_lo});
    assign full_thr  = AW'({f_hi, f_lo});
endmodule

// File: rtl/pflag_fifo.sv
// Dual-clock FIFO top: pointers, cross-domain synchronisers, flags and threshold loader.
// Assumes DEPTH is 256, 512, 1024, 2048 or 4096. The thresholds change only while the
// read side is idle, because the read domain uses the empty threshold without resampling.
module pflag_fifo #(
    parameter int DW          = 18,
    parameter int DEPTH       = 256,
    parameter int THR_DEFAULT = 7
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic          load_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    output logic          almost_full,
    output logic          half_full,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          almost_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

    logic [PW-1:0] w_bin, w_gray, r_bin, r_gray;
    logic [PW-1:0] r_gray_w, w_gray_r, r_bin_w, w_bin_r;
    logic [PW-1:0] w_used, w_free, r_used;
    logic [AW-1:0] empty_thr, full_thr;
    logic          wr_go, rd_go;

    // Convert a Gray-coded pointer back to binary.
    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // Write side: accept a data write only outside a load and while not full.
    assign wr_go = wr_en & ~load_en & ~full;

    pflag_ptr #(.PW(PW)) u_wptr (
        .clk(wr_clk), .rst_n(wr_rst_n), .inc(wr_go), .bin(w_bin), .gray(w_gray)
    );

    pflag_sync2 #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(r_gray), .q(r_gray_w)
    );

    pflag_thr_load #(.AW(AW), .THR_DEFAULT(THR_DEFAULT)) u_thr (
        .clk(wr_clk), .rst_n(wr_rst_n), .load_en(load_en), .wr_en(wr_en),
        .din(wr_data[7:0]), .empty_thr(empty_thr), .full_thr(full_thr)
    );

    // Write-domain occupancy and the flags derived from it.
    always_comb begin
        r_bin_w     = gray2bin(r_gray_w);
        w_used      = w_bin - r_bin_w;
        w_free      = DEPTH_P - w_used;
        full        = (w_used == DEPTH_P);
        half_full   = (w_used > HALF_P);
        almost_full = (w_free <= {1'b0, full_thr});
    end

    // Read side: accept a read only while not empty.
    assign rd_go = rd_en & ~empty;

    pflag_ptr #(.PW(PW)) u_rptr (
        .clk(rd_clk), .rst_n(rd_rst_n), .inc(rd_go), .bin(r_bin), .gray(r_gray)
    );

    pflag_sync2 #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(w_gray), .q(w_gray_r)
    );

    // Read-domain occupancy and the flags derived from it.
    always_comb begin
        w_bin_r      = gray2bin(w_gray_r);
        r_used       = w_bin_r - r_bin;
        empty        = (r_used == '0);
        almost_empty = (r_used <= {1'b0, empty_thr});
    end

    pflag_ram #(.DW(DW), .AW(AW)) u_mem (
        .wr_clk(wr_clk), .we(wr_go), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .re(rd_go), .raddr(r_bin[AW-1:0]),
        .rdata(rd_data)
    );
endmodule

// File: rtl/pflag_fifo_chk.sv
// Property checker for the dual-clock FIFO, attached to the top by bind.
// Assumes pointer names inside the top as connected below.
module pflag_fifo_chk #(
    parameter int PW = 9
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          wr_en,
    input logic          load_en,
    input logic          rd_en,
    input logic          full,
    input logic          empty,
    input logic [PW-1:0] w_bin,
    input logic [PW-1:0] r_bin,
    input logic [PW-1:0] w_gray,
    input logic [PW-1:0] r_gray
);
    // R3: a write into a full buffer leaves the write pointer where it was.
    a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (full && wr_en) |=> $stable(w_bin));

    // R4: a read from an empty buffer leaves the read pointer where it was.
    a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (empty && rd_en) |=> $stable(r_bin));

    // R8: a load cycle pushes no word into the queue.
    a_r8_load_no_push: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        load_en |=> $stable(w_bin));

    // R10: the write-side Gray pointer steps by at most one bit.
    a_r10_wgray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    // R10: the read-side Gray pointer steps by at most one bit.
    a_r10_rgray_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1);
endmodule

bind pflag_fifo pflag_fifo_chk #(.PW(PW)) u_chk (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .wr_en(wr_en), .load_en(load_en), .rd_en(rd_en), .full(full), .empty(empty),
    .w_bin(w_bin), .r_bin(r_bin), .w_gray(w_gray), .r_gray(r_gray)
);

// File: tb/pflag_fifo_tb.sv
// Scoreboard bench: the driver queues expected words, the monitor pops and compares them.
module pflag_fifo_tb;
    localparam int DEPTH = 256;
    localparam int DW    = 18;

    logic wclk = 1'b0, rclk_a = 1'b0, async_mode = 1'b0;
    logic rd_clk;
    always #10 wclk   = ~wclk;
    always #7  rclk_a = ~rclk_a;
    assign rd_clk = async_mode ? rclk_a : wclk;

    logic wr_rst_n, rd_rst_n, wr_en, load_en, rd_en;
    logic [DW-1:0] wr_data, rd_data;
    logic full, almost_full, half_full, empty, almost_empty;

    pflag_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .wr_clk(wclk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .load_en(load_en),
        .wr_data(wr_data), .full(full), .almost_full(almost_full), .half_full(half_full),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .almost_empty(almost_empty)
    );

    int n_chk = 0, n_bad = 0;
    int ae_m = 7, af_m = 7;
    logic [DW-1:0] q[$];
    bit rd_allow = 0, rd_force = 0, done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each accepted read against the head of the queue.
    initial begin
        bit pend;
        pend  = 0;
        rd_en = 0;
        forever begin
            @(negedge rd_clk);
            if (pend) begin
                if (q.size() == 0) check("R1 read with nothing expected", 1, 0);
                else check("R1 data order", 32'(rd_data), 32'(q.pop_front()));
            end
            pend = 0;
            if (rd_allow && !empty) begin
                rd_en = 1;
                pend  = 1;
            end else begin
                rd_en = rd_force;
            end
        end
    end

    task automatic push(input logic [DW-1:0] d);
        @(negedge wclk);
        wr_en = 1; wr_data = d; q.push_back(d);
        @(negedge wclk);
        wr_en = 0;
    endtask

    task automatic load_byte(input logic [7:0] b);
        @(negedge wclk);
        wr_en = 1; wr_data = DW'(b);
        @(negedge wclk);
        wr_en = 0;
    endtask

    task automatic settle();
        repeat (5) @(negedge wclk);
    endtask

    task automatic flags_at(input int n);
        check("R5 empty",        32'(empty),        32'(n == 0));
        check("R5 full",         32'(full),         32'(n == DEPTH));
        check("R6 half_full",    32'(half_full),    32'(n > DEPTH / 2));
        check("R7 almost_empty", 32'(almost_empty), 32'(n <= ae_m));
        check("R7 almost_full",  32'(almost_full),  32'((DEPTH - n) <= af_m));
    endtask

    task automatic drain();
        rd_allow = 1;
        wait (q.size() == 0);
        settle();
        rd_allow = 0;
    endtask

    // Main sequence.
    initial begin
        wr_rst_n = 0; rd_rst_n = 0; wr_en = 0; load_en = 0; wr_data = '0;
        repeat (5) @(negedge wclk);
        wr_rst_n = 1; rd_rst_n = 1;
        @(negedge wclk);

        // R2: reset state
        check("R2 empty",        32'(empty), 1);
        check("R2 almost_empty", 32'(almost_empty), 1);
        check("R2 full",         32'(full), 0);
        check("R2 almost_full",  32'(almost_full), 0);
        check("R2 half_full",    32'(half_full), 0);
        check("R2 rd_data",      32'(rd_data), 0);

        // R4: reads while empty are dropped
        rd_force = 1;
        repeat (4) @(negedge wclk);
        rd_force = 0;
        @(negedge wclk);
        check("R4 empty held", 32'(empty), 1);
        check("R4 rd_data held", 32'(rd_data), 0);
        push(18'h2AAAA);
        drain();
        check("R4 pointer unmoved, word read once", 32'(empty), 1);
        check("R4 word content", 32'(rd_data), 32'h2AAAA);

        // R5 R6 R7: flags at every fill level with default thresholds
        for (int n = 1; n <= DEPTH; n++) begin
            push(DW'((n * 769) ^ 'h15555));
            settle();
            flags_at(n);
        end

        // R3: writes into a full buffer are dropped
        @(negedge wclk);
        wr_en = 1; wr_data = 18'h3FFFF;
        repeat (3) @(negedge wclk);
        wr_en = 0;
        settle();
        check("R3 full held", 32'(full), 1);
        drain();
        check("R3 no extra word", 32'(empty), 1);

        // R8: rotation with wrap; the fifth byte lands in the empty-low field again
        @(negedge wclk);
        load_en = 1;
        load_byte(8'd3); load_byte(8'd0); load_byte(8'd10); load_byte(8'd0); load_byte(8'd2);
        @(negedge wclk);
        load_en = 0;
        ae_m = 2; af_m = 10;
        settle();
        check("R8 load pushes no word", 32'(empty), 1);
        for (int n = 1; n <= 3; n++) begin
            push(DW'(n + 'h100));
            settle();
            flags_at(n);
        end

        // R9: after load_en drops, the next byte goes to the empty-low field
        @(negedge wclk);
        load_en = 1;
        load_byte(8'd4);
        @(negedge wclk);
        load_en = 0;
        ae_m = 4;
        settle();
        check("R9 rotation restarted", 32'(almost_empty), 1);
        for (int n = 4; n <= DEPTH; n++) begin
            push(DW'((n * 4099) ^ 'h2D2D2));
            settle();
            flags_at(n);
        end
        drain();
        check("R5 empty after drain", 32'(empty), 1);

        // R1: unrelated clocks, concurrent traffic with a read pause
        async_mode = 1;
        settle();
        rd_allow = 1;
        fork
            begin
                for (int i = 0; i < 400; i++) begin
                    @(negedge wclk);
                    while (full) @(negedge wclk);
                    wr_en = 1; wr_data = DW'(i * 2311 + 5); q.push_back(wr_data);
                    @(negedge wclk);
                    wr_en = 0;
                end
            end
            begin
                repeat (100) @(negedge rd_clk);
                rd_allow = 0;
                repeat (300) @(negedge rd_clk);
                rd_allow = 1;
            end
        join
        wait (q.size() == 0);
        settle();
        check("R1 async stream drained", 32'(empty), 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge wclk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule